// File: doc/BRIEF.md
# SPI Slave Port with CPU Register Window

This block lets a CPU act as a slave on a four-wire serial bus. An external master controls the transfers through its serial clock and active-low select lines. All three bus inputs arrive asynchronously. The block passes each one through a two-flop synchronizer and finds the serial clock edges in the system clock domain. For this to work, the system clock must run at least four times faster than the serial clock.

The CPU sees four 16-bit registers. Writing the transmit register loads a word into a holding stage. Whenever no word is being shifted, the holding stage moves into the shift register, so the first bit is already on `miso` when the master selects the slave. Each received word is copied into the receive register. Status flags report ready, busy and overrun conditions. A per-bit enable mask in the control register merges those flags into a single interrupt.

The word width (1 to 16), the bit order, the clock idle level and the sampling phase are parameters. `miso` has no tri-state driver inside the block. Instead, `miso_oe` follows the select input so that an external buffer can release the line.

Top module: `spi_word_slave`

## Requirements
- R1: After reset, status reads 0x0040 (only the transmit-ready bit set), the receive and control registers read 0, and `irq` is 0.
- R2: Register address 0 is the received word (read-only), address 1 is the transmit word (write-only, reads 0), address 2 is status and address 3 is control. Control keeps bits 8..3 and reads 0 in every other bit.
- R3: A word received while selected goes to the receive register after the sample edge of its last bit, and the receive-ready bit (status bit 7) is set. Bits are sampled on the leading clock edge when the phase parameter is 0 and on the trailing edge when it is 1. The first bit is the MSB unless LSB-first is chosen.
- R4: When select goes low, `miso` already carries the first bit of the loaded word. Each further bit appears on the shifting edge, which is the edge that is not the sample edge.
- R5: While select is high, serial clock and `mosi` activity has no effect: no bit is counted, nothing is received, and a later word is received intact.
- R6: A completed word always overwrites the receive register. If receive-ready was still set, the receive overrun bit (status bit 3) is also set. A read of address 0 clears receive-ready.
- R7: A write to the transmit register while transmit-ready (status bit 6) is 0 sets the transmit overrun bit (status bit 4), and the written word is discarded.
- R8: The holding word moves to the shift register whenever no word is being shifted, and transmit-ready then returns to 1. Status bit 5 stays 1 from that load until the word completes or is aborted.
- R9: A write to status clears both overrun bits. Status bit 8 reads as the OR of the two overrun bits.
- R10: `irq` is high exactly when some status bit in 8..3 and the control bit at the same position are both 1.
- R11: If select rises before a word is complete, the partial word is discarded, the bit count restarts and the unfinished transmit word is dropped.
- R12: `miso_oe` is the inverse of the select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the master (asynchronous) |
| ssel_n_in | input | 1 | Active-low select from the master (asynchronous) |
| mosi_in | input | 1 | Serial data from the master (asynchronous) |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Enable for an external `miso` tri-state buffer |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on address 0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a word abandoned halfway. The stimulus raises select after three clock pulses, then confirms that receive-ready stayed low and that the next full transfer arrives without stray bits. Overruns are provoked deliberately. The CPU runs two transfers without reading the receive register, and it writes the transmit register three times while idle, so that the holding stage is full when the third write lands. The bench then checks which word survives in each case.

// File: rtl/spi_word_slave.sv
module spi_word_slave #(
  parameter int WIDTH     = 8,
  parameter bit LSB_FIRST = 1'b0,
  parameter bit CPOL      = 1'b0,
  parameter bit CPHA      = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_in,
  input  logic        ssel_n_in,
  input  logic        mosi_in,
  output logic        miso_out,
  output logic        miso_oe,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [2:0]       sclk_s;
  logic [1:0]       ssel_s, mosi_s;
  logic             sel, edge_ev, lead_ev, trail_ev, sample_ev, shift_ev;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] tx_sh, rx_sh, rx_nxt, tx_nxt, hold, rxdata;
  logic             hold_full, sh_full, rrdy, roe, toe;
  logic [5:0]       ctrl, stat;
  logic             last_bit, wr_tx, wr_st, rd_rx, unused_bits;

  assign sel       = ~ssel_s[1];
  assign edge_ev   = sel && (sclk_s[1] != sclk_s[2]);
  assign lead_ev   = edge_ev && (sclk_s[1] != CPOL);
  assign trail_ev  = edge_ev && (sclk_s[1] == CPOL);
  assign sample_ev = CPHA ? trail_ev : lead_ev;
  assign shift_ev  = CPHA ? lead_ev : trail_ev;
  assign last_bit  = (cnt == CW'(WIDTH - 1));

  assign rx_nxt = LSB_FIRST ? ((rx_sh >> 1) | (WIDTH'(mosi_s[1]) << (WIDTH - 1)))
                            : ((rx_sh << 1) | WIDTH'(mosi_s[1]));
  assign tx_nxt = LSB_FIRST ? (tx_sh >> 1) : (tx_sh << 1);

  assign miso_out = LSB_FIRST ? tx_sh[0] : tx_sh[WIDTH-1];
  assign miso_oe  = ~ssel_n_in;

  assign wr_tx = reg_wr && (reg_addr == 2'd1);
  assign wr_st = reg_wr && (reg_addr == 2'd2);
  assign rd_rx = reg_rd && (reg_addr == 2'd0);

  assign stat = {roe | toe, rrdy, ~hold_full, sh_full, toe, roe};
  assign irq  = |(stat & ctrl);
  assign unused_bits = ^reg_wdata;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 16'(rxdata);
      2'd2:    reg_rdata = {7'd0, stat, 3'd0};
      2'd3:    reg_rdata = {7'd0, ctrl, 3'd0};
      default: reg_rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s    <= {3{CPOL}};
      ssel_s    <= 2'b11;
      mosi_s    <= 2'b00;
      cnt       <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      hold      <= '0;
      rxdata    <= '0;
      hold_full <= 1'b0;
      sh_full   <= 1'b0;
      rrdy      <= 1'b0;
      roe       <= 1'b0;
      toe       <= 1'b0;
      ctrl      <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_in};
      ssel_s <= {ssel_s[0], ssel_n_in};
      mosi_s <= {mosi_s[0], mosi_in};

      if (reg_wr && reg_addr == 2'd3) ctrl <= reg_wdata[8:3];
      if (rd_rx) rrdy <= 1'b0;
      if (wr_st) begin
        roe <= 1'b0;
        toe <= 1'b0;
      end
      if (wr_tx) begin
        if (hold_full) toe <= 1'b1;
        else begin
          hold      <= reg_wdata[WIDTH-1:0];
          hold_full <= 1'b1;
        end
      end

      if (!sel && cnt != '0) begin
        cnt     <= '0;
        sh_full <= 1'b0;
      end else if (sample_ev) begin
        rx_sh <= rx_nxt;
        if (last_bit) begin
          cnt     <= '0;
          rxdata  <= rx_nxt;
          rrdy    <= 1'b1;
          sh_full <= 1'b0;
          if (rrdy) roe <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (shift_ev && cnt != '0) begin
        tx_sh <= tx_nxt;
      end else if (hold_full && !sh_full && cnt == '0) begin
        tx_sh     <= hold;
        sh_full   <= 1'b1;
        hold_full <= 1'b0;
      end
    end
  end

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WIDTH - 1));
  a_r5_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> cnt == '0);
  a_r6_roe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(roe) |-> $past(rrdy));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !sample_ev) |=> !rrdy);
  a_r7_toe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(toe) |-> $past(wr_tx && hold_full));
  a_r8_hold_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !sh_full && !sel && cnt == '0) |=> !hold_full);
  a_r9_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && !wr_tx && !sample_ev) |=> (!roe && !toe));
endmodule

// File: tb/spi_word_slave_test.sv
module spi_word_slave_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, ssn = 1'b1, mosi = 1'b0;
  logic miso, oe, wr = 1'b0, rd = 1'b0, irq;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = 16'd0, rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam logic [15:0] VEC [0:5] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                        16'h817E, 16'h5AC3, 16'h0180};

  spi_word_slave uut (.clk(clk), .rst_n(rst_n), .sclk_in(sclk), .ssel_n_in(ssn),
    .mosi_in(mosi), .miso_out(miso), .miso_oe(oe), .reg_addr(addr), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] m, input int nbits, output logic [7:0] s);
    s = 8'h00;
    @(negedge clk); ssn = 1'b0;
    tick(5);
    for (int i = 0; i < nbits; i++) begin
      mosi = m[7-i];
      tick(5);
      s[7-i] = miso;
      sclk = 1'b1;
      tick(5);
      sclk = 1'b0;
    end
    tick(5);
    ssn = 1'b1;
    tick(4);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [7:0] s;
    tick(3); rst_n = 1'b1; tick(2);

    rreg(2'd2, r); check("R1 status", r, 16'h0040);
    rreg(2'd0, r); check("R1 rxdata", r, 16'h0000);
    rreg(2'd3, r); check("R1 control", r, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R12 oe idle", {15'd0, oe}, 16'd0);

    for (int k = 0; k < 6; k++) begin
      wreg(2'd1, {8'd0, VEC[k][15:8]});
      tick(2);
      rreg(2'd2, r); check("R8 loaded", r & 16'h0060, 16'h0060);
      xfer(VEC[k][7:0], 8, s);
      check("R4 miso word", {8'd0, s}, {8'd0, VEC[k][15:8]});
      rreg(2'd2, r); check("R3 rrdy", r & 16'h00A0, 16'h0080);
      rreg(2'd0, r); check("R3 rxdata", r, {8'd0, VEC[k][7:0]});
      rreg(2'd2, r); check("R6 read clears", r & 16'h0080, 16'h0000);
    end

    @(negedge clk); ssn = 1'b0; tick(4);
    check("R12 oe selected", {15'd0, oe}, 16'd1);
    ssn = 1'b1; tick(4);

    wreg(2'd1, 16'h00C1); tick(2);
    wreg(2'd1, 16'h0042);
    rreg(2'd2, r); check("R8 hold full", r & 16'h0060, 16'h0020);
    wreg(2'd1, 16'h0099);
    rreg(2'd2, r); check("R7 toe", r & 16'h0110, 16'h0110);
    xfer(8'h11, 8, s); check("R4 first word", {8'd0, s}, 16'h00C1);
    xfer(8'h22, 8, s); check("R7 dropped", {8'd0, s}, 16'h0042);
    rreg(2'd2, r); check("R6 roe", r & 16'h0188, 16'h0188);
    rreg(2'd0, r); check("R6 overwrite", r, 16'h0022);
    wreg(2'd2, 16'h0000);
    rreg(2'd2, r); check("R9 clear", r & 16'h0118, 16'h0000);

    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      mosi = i[0]; sclk = 1'b1; tick(5); sclk = 1'b0; tick(5);
    end
    rreg(2'd2, r); check("R5 ignored", r & 16'h0080, 16'h0000);
    wreg(2'd1, 16'h003C); tick(2);
    xfer(8'hE0, 3, s);
    rreg(2'd2, r); check("R11 abort", r & 16'h00A0, 16'h0000);
    wreg(2'd1, 16'h0096); tick(2);
    xfer(8'h5B, 8, s);
    check("R11 next tx", {8'd0, s}, 16'h0096);
    rreg(2'd0, r); check("R11 next rx", r, 16'h005B);
    check("R5 intact", r, 16'h005B);

    wreg(2'd3, 16'hFFFF);
    rreg(2'd3, r); check("R2 ctrl mask", r, 16'h01F8);
    rreg(2'd1, r); check("R2 tx reads 0", r, 16'h0000);
    wreg(2'd3, 16'h0040); tick(1);
    check("R10 irq on", {15'd0, irq}, 16'd1);
    wreg(2'd3, 16'h0080); tick(1);
    check("R10 irq off", {15'd0, irq}, 16'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule